// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from the moment it raises an exception to the first fetch of the handler. It accepts one exception vector at a time and latches the core's stack pointer, stack selector, flags, code selector and instruction pointer. It then fetches the vector's 16-byte gate from a descriptor table in memory as two 64-bit reads. If the gate is usable, it pushes the interrupt frame onto the aligned stack through a memory write port. Finally it presents the handler address, the handler's code selector, the new stack pointer and the new flags, together with a one-cycle completion pulse.

Escalation is part of delivery. An unusable gate, or a fault reported by memory during any read or push, restarts delivery as a double fault on vector 8 with an error code of zero. Delivery of a double fault that fails in the same way does not enter any handler. It ends in a one-cycle shutdown pulse that the surrounding system uses as a reset request.

Top module: `exc_entry_seq`

## Requirements
- R1: The gate for vector V is read as two 8-byte words: the first at idt_base + 16*V (gate bytes 0-7), the second at idt_base + 16*V + 8 (gate bytes 8-15). Both reads are little-endian.
- R2: On completion, new_rip = {word1[31:0], word0[63:48], word0[15:0]} and new_cs = word0[31:16].
- R3: The options word is word0[47:32]. The gate is usable only when bit 15 is 1, bits 11:9 are all 1 and bit 12 is 0. Any other pattern restarts delivery as vector 8 with an error code of 0.
- R4: A mem_fault response to any read or push during ordinary delivery restarts delivery as vector 8 with an error code of 0, using the originally latched core state.
- R5: During double-fault delivery (either requested as vector 8 or reached by escalation), an unusable gate or a mem_fault produces a one-cycle shutdown pulse. No done pulse follows and no further access is made.
- R6: When options bit 8 is 0, new_rflags equals the latched flags with bit 9 cleared. When options bit 8 is 1, new_rflags equals the latched flags.
- R7: The frame top is the latched rsp with its low 4 bits cleared. The second push stores the rsp value from before this alignment.
- R8: Pushes go to frame top - 8, -16, -24 and so on. They store, in this order: ss zero-extended, old rsp, rflags, cs zero-extended, rip, and then the error code when the vector carries one.
- R9: Vectors 8, 10, 11, 12, 13, 14 and 17 push an error code, which makes 6 pushes. All other vectors make 5 pushes.
- R10: busy rises in the cycle after exc_req is accepted in idle. It stays high through the cycle of the done or shutdown pulse and falls after it. A request raised while busy is ignored, and so are changes on the core-state inputs while busy.
- R11: On completion, new_rsp equals the address of the last push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request, taken when idle |
| exc_vec | input | 8 | Exception vector |
| exc_err | input | 64 | Error code for vectors that push one |
| cur_rsp | input | 64 | Core stack pointer |
| cur_ss | input | 16 | Core stack selector |
| cur_rflags | input | 64 | Core flags |
| cur_cs | input | 16 | Core code selector |
| cur_rip | input | 64 | Core instruction pointer |
| idt_base | input | 64 | Descriptor table base address |
| rd_en | output | 1 | Read request, held until answered |
| rd_addr | output | 64 | Read address |
| rd_ack | input | 1 | Read completed, data valid |
| rd_data | input | 64 | Read data |
| wr_en | output | 1 | Write request, held until answered |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Write data |
| wr_ack | input | 1 | Write completed |
| mem_fault | input | 1 | Outstanding access faulted (wins over ack) |
| busy | output | 1 | Delivery in progress |
| done | output | 1 | One-cycle completion pulse |
| shutdown | output | 1 | One-cycle reset request after a failed double fault |
| new_rip | output | 64 | Handler address |
| new_cs | output | 16 | Handler code selector |
| new_rsp | output | 64 | Stack pointer after the frame |
| new_rflags | output | 64 | Flags on handler entry |

## Verification
Random vectors over the full 8-bit range set vectors with and without an error code against each other and usable gates against unusable ones. Random stack pointers with arbitrary low bits show whether alignment and the saved pre-alignment value are kept apart. Random fault positions, injected into read or push accesses together with random memory stalls, show single escalation apart from shutdown, and show whether a restart reuses the latched state. Directed cases cover interrupt versus trap gates, a present bit cleared against a wrong type pattern, a double fault whose own gate is unusable, and a second request with changed core inputs raised during delivery.

// File: rtl/ees_pkg.sv
package ees_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD_LO = 3'd1,
    S_RD_HI = 3'd2,
    S_PUSH  = 3'd3,
    S_FIN   = 3'd4,
    S_RST   = 3'd5
  } ees_state_e;

  // Vectors whose frame ends with an error code word.
  function automatic logic vec_pushes_code(input logic [7:0] v);
    case (v)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ees_gate_decode.sv
module ees_gate_decode #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16
) (
  input  logic [XLEN-1:0]  word_lo,
  input  logic [XLEN-1:0]  word_hi,
  output logic [XLEN-1:0]  handler,
  output logic [SEL_W-1:0] selector,
  output logic             gate_ok,
  output logic             trap_gate
);
  localparam int OPT_LSB   = 32;
  localparam int PRESENT_B = 15;
  localparam int TRAP_B    = 8;
  localparam int ZERO_B    = 12;

  logic [15:0] opts;

  assign opts      = word_lo[OPT_LSB +: 16];
  assign selector  = word_lo[16 +: SEL_W];
  assign handler   = {word_hi[31:0], word_lo[63:48], word_lo[15:0]};
  assign trap_gate = opts[TRAP_B];
  assign gate_ok   = opts[PRESENT_B] && (opts[11:9] == 3'b111) && !opts[ZERO_B];

endmodule

// File: rtl/ees_frame_slot.sv
module ees_frame_slot #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [XLEN-1:0]  frame_top,
  input  logic [IDX_W-1:0] idx,
  input  logic [SEL_W-1:0] ss,
  input  logic [XLEN-1:0]  old_rsp,
  input  logic [XLEN-1:0]  rflags,
  input  logic [SEL_W-1:0] cs,
  input  logic [XLEN-1:0]  rip,
  input  logic [XLEN-1:0]  err,
  output logic [XLEN-1:0]  slot_addr,
  output logic [XLEN-1:0]  slot_data
);
  localparam int SLOTS   = 6;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SLOT_B  = XLEN / 8;

  logic [XLEN-1:0] words [ENTRIES];

  assign words[0] = {{(XLEN-SEL_W){1'b0}}, ss};
  assign words[1] = old_rsp;
  assign words[2] = rflags;
  assign words[3] = {{(XLEN-SEL_W){1'b0}}, cs};
  assign words[4] = rip;
  assign words[5] = err;

  generate
    for (genvar g = SLOTS; g < ENTRIES; g++) begin : g_pad
      assign words[g] = '0;
    end
  endgenerate

  logic [XLEN-1:0] idx_ext;
  assign idx_ext   = {{(XLEN-IDX_W){1'b0}}, idx};
  assign slot_addr = frame_top - (idx_ext + XLEN'(1)) * XLEN'(SLOT_B);
  assign slot_data = words[idx];

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN     = 64,
  parameter int SEL_W    = 16,
  parameter int VEC_W    = 8,
  parameter int DF_VEC   = 8,
  parameter int IF_BIT   = 9,
  parameter int ALIGN_LG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic [XLEN-1:0]  exc_err,
  input  logic [XLEN-1:0]  cur_rsp,
  input  logic [SEL_W-1:0] cur_ss,
  input  logic [XLEN-1:0]  cur_rflags,
  input  logic [SEL_W-1:0] cur_cs,
  input  logic [XLEN-1:0]  cur_rip,
  input  logic [XLEN-1:0]  idt_base,
  output logic             rd_en,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_ack,
  input  logic [XLEN-1:0]  rd_data,
  output logic             wr_en,
  output logic [XLEN-1:0]  wr_addr,
  output logic [XLEN-1:0]  wr_data,
  input  logic             wr_ack,
  input  logic             mem_fault,
  output logic             busy,
  output logic             done,
  output logic             shutdown,
  output logic [XLEN-1:0]  new_rip,
  output logic [SEL_W-1:0] new_cs,
  output logic [XLEN-1:0]  new_rsp,
  output logic [XLEN-1:0]  new_rflags
);
  import ees_pkg::*;

  localparam int IDX_W    = 3;
  localparam int SLOT_B   = XLEN / 8;
  localparam int DESC_LG  = 4;
  localparam logic [IDX_W-1:0] LAST_CODE  = IDX_W'(5);
  localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(4);
  localparam logic [XLEN-1:0]  ALIGN_MASK = ~((XLEN'(1) << ALIGN_LG) - XLEN'(1));

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ees_state_e state_q, state_d;
  logic             dbl_q, dbl_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [XLEN-1:0]  err_q, err_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic [SEL_W-1:0] ss_q, cs_q, sel_q;
  logic [XLEN-1:0]  rsp_q, rfl_q, rip_q, lo_q, hand_q;
  logic             trap_q;

  logic cap_en, lo_en, gate_en, out_en, esc;

  // gate decode works on the stored low word and the arriving high word
  logic [XLEN-1:0]  dec_handler;
  logic [SEL_W-1:0] dec_sel;
  logic             gate_ok, dec_trap;

  ees_gate_decode #(.XLEN(XLEN), .SEL_W(SEL_W)) u_dec (
    .word_lo  (lo_q),
    .word_hi  (rd_data),
    .handler  (dec_handler),
    .selector (dec_sel),
    .gate_ok  (gate_ok),
    .trap_gate(dec_trap)
  );

  logic [XLEN-1:0] frame_top, slot_addr, slot_data;
  assign frame_top = rsp_q & ALIGN_MASK;

  ees_frame_slot #(.XLEN(XLEN), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_frame (
    .frame_top(frame_top),
    .idx      (idx_q),
    .ss       (ss_q),
    .old_rsp  (rsp_q),
    .rflags   (rfl_q),
    .cs       (cs_q),
    .rip      (rip_q),
    .err      (err_q),
    .slot_addr(slot_addr),
    .slot_data(slot_data)
  );

  logic [IDX_W-1:0] last_idx;
  logic [XLEN-1:0]  desc_addr, frame_bytes;
  assign last_idx    = vec_pushes_code(8'(vec_q)) ? LAST_CODE : LAST_PLAIN;
  assign desc_addr   = idt_base + ({{(XLEN-VEC_W){1'b0}}, vec_q} << DESC_LG);
  assign frame_bytes = ({{(XLEN-IDX_W){1'b0}}, last_idx} + XLEN'(1)) * XLEN'(SLOT_B);

  // memory ports
  assign rd_en   = (state_q == S_RD_LO) || (state_q == S_RD_HI);
  assign rd_addr = (state_q == S_RD_HI) ? desc_addr + XLEN'(SLOT_B) : desc_addr;
  assign wr_en   = (state_q == S_PUSH);
  assign wr_addr = slot_addr;
  assign wr_data = slot_data;

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FIN);
  assign shutdown = (state_q == S_RST);

  // next-state
  always_comb begin
    state_d = state_q;
    dbl_d   = dbl_q;
    vec_d   = vec_q;
    err_d   = err_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    lo_en   = 1'b0;
    gate_en = 1'b0;
    out_en  = 1'b0;
    esc     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (exc_req) begin
          cap_en  = 1'b1;
          vec_d   = exc_vec;
          err_d   = exc_err;
          dbl_d   = (exc_vec == VEC_W'(DF_VEC));
          state_d = S_RD_LO;
        end
      end
      S_RD_LO: begin
        if (mem_fault) esc = 1'b1;
        else if (rd_ack) begin
          lo_en   = 1'b1;
          state_d = S_RD_HI;
        end
      end
      S_RD_HI: begin
        if (mem_fault || (rd_ack && !gate_ok)) esc = 1'b1;
        else if (rd_ack) begin
          gate_en = 1'b1;
          idx_d   = '0;
          state_d = S_PUSH;
        end
      end
      S_PUSH: begin
        if (mem_fault) esc = 1'b1;
        else if (wr_ack) begin
          if (idx_q == last_idx) begin
            out_en  = 1'b1;
            state_d = S_FIN;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      S_FIN:   state_d = S_IDLE;
      S_RST:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (esc) begin
      if (dbl_q) begin
        state_d = S_RST;
      end else begin
        dbl_d   = 1'b1;
        vec_d   = VEC_W'(DF_VEC);
        err_d   = '0;
        state_d = S_RD_LO;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      state_q <= S_IDLE;
      dbl_q   <= 1'b0;
      vec_q   <= '0;
      err_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      dbl_q   <= dbl_d;
      vec_q   <= vec_d;
      err_q   <= err_d;
      idx_q   <= idx_d;
    end
  end

  // datapath registers, enabled loads, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ss_q  <= cur_ss;
      rsp_q <= cur_rsp;
      rfl_q <= cur_rflags;
      cs_q  <= cur_cs;
      rip_q <= cur_rip;
    end
    if (lo_en) begin
      lo_q <= rd_data;
    end
    if (gate_en) begin
      hand_q <= dec_handler;
      sel_q  <= dec_sel;
      trap_q <= dec_trap;
    end
    if (out_en) begin
      new_rip    <= hand_q;
      new_cs     <= sel_q;
      new_rsp    <= frame_top - frame_bytes;
      new_rflags <= trap_q ? rfl_q : (rfl_q & ~(XLEN'(1) << IF_BIT));
    end
  end

endmodule

// File: rtl/ees_checker.sv
module ees_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic [XLEN-1:0] rd_addr,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_addr,
  input logic [XLEN-1:0] idt_base,
  input logic            busy,
  input logic            done,
  input logic            shutdown,
  input logic [XLEN-1:0] new_rsp
);

  p_term_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && shutdown));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !shutdown) |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_shut_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!shutdown && !busy));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en));

  p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_push_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[2:0] == 3'b000));

  p_gate_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[2:0] == idt_base[2:0]));

  p_new_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_rsp[2:0] == 3'b000));

endmodule

bind exc_entry_seq ees_checker #(.XLEN(XLEN)) u_ees_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .idt_base(idt_base),
  .busy    (busy),
  .done    (done),
  .shutdown(shutdown),
  .new_rsp (new_rsp)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req;
  logic [7:0]  exc_vec;
  logic [63:0] exc_err, cur_rsp, cur_rflags, cur_rip, idt_base;
  logic [15:0] cur_ss, cur_cs;
  logic        rd_en, rd_ack, wr_en, wr_ack, mem_fault;
  logic [63:0] rd_addr, rd_data, wr_addr, wr_data;
  logic        busy, done, shutdown;
  logic [63:0] new_rip, new_rsp, new_rflags;
  logic [15:0] new_cs;

  always #2 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec), .exc_err(exc_err),
    .cur_rsp(cur_rsp), .cur_ss(cur_ss), .cur_rflags(cur_rflags), .cur_cs(cur_cs),
    .cur_rip(cur_rip), .idt_base(idt_base), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .mem_fault(mem_fault), .busy(busy),
    .done(done), .shutdown(shutdown), .new_rip(new_rip), .new_cs(new_cs),
    .new_rsp(new_rsp), .new_rflags(new_rflags)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] tbl_lo [256];
  logic [63:0] tbl_hi [256];

  // observed and expected access logs
  logic [63:0] act_addr [64];
  logic [63:0] act_data [64];
  logic        act_wr   [64];
  int          act_n;
  logic [63:0] exp_addr [64];
  logic [63:0] exp_data [64];
  logic        exp_wr   [64];
  int          exp_n;
  logic        exp_shut;
  logic [63:0] exp_rip, exp_rsp, exp_rfl;
  logic [15:0] exp_cs;

  int fa, fb, acc_k;
  bit stall_on;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit has_code(input int v);
    return (v == 8) || (v == 10) || (v == 11) || (v == 12) || (v == 13) || (v == 14) || (v == 17);
  endfunction

  function automatic logic [63:0] mem_read(input logic [63:0] a);
    logic [63:0] off;
    off = a - idt_base;
    if (off < 64'd4096 && off[2:0] == 3'b0)
      return off[3] ? tbl_hi[off[11:4]] : tbl_lo[off[11:4]];
    return 64'hBAD0_BAD0_BAD0_BAD0;
  endfunction

  function automatic void set_gate(input int v, input logic [63:0] h, input logic [15:0] sel, input logic [15:0] opts);
    tbl_lo[v] = {h[31:16], opts, sel, h[15:0]};
    tbl_hi[v] = {$urandom(), h[63:32]};
  endfunction

  // memory model: answers each held request at the falling edge
  always @(negedge clk) begin
    rd_ack = 1'b0; wr_ack = 1'b0; mem_fault = 1'b0; rd_data = '0;
    if (rst_n && (rd_en || wr_en) && !(stall_on && ($urandom() % 3 == 0))) begin
      if (act_n < 64) begin
        act_addr[act_n] = rd_en ? rd_addr : wr_addr;
        act_data[act_n] = rd_en ? 64'd0 : wr_data;
        act_wr[act_n]   = wr_en;
        act_n++;
      end
      if (acc_k == fa || acc_k == fb) mem_fault = 1'b1;
      else if (rd_en) begin rd_ack = 1'b1; rd_data = mem_read(rd_addr); end
      else wr_ack = 1'b1;
      acc_k++;
    end
  end

  task automatic add_exp(input logic [63:0] a, input logic w, input logic [63:0] d);
    exp_addr[exp_n] = a; exp_wr[exp_n] = w; exp_data[exp_n] = d; exp_n++;
  endtask

  task automatic model(input int vec, input logic [63:0] err, input logic [15:0] ss,
                       input logic [63:0] rsp, input logic [63:0] rfl, input logic [15:0] cs,
                       input logic [63:0] rip);
    bit lvl, fin, bad;
    int v, k, n;
    logic [63:0] e, lo, hi, top;
    logic [15:0] opts;
    logic [63:0] fr [6];
    lvl = (vec == 8); v = vec; e = err; k = 0; exp_n = 0; fin = 0;
    while (!fin) begin
      bad = 0;
      for (int r = 0; r < 2 && !bad; r++) begin
        add_exp(idt_base + 64'(16 * v) + 64'(8 * r), 1'b0, 64'd0);
        if (k == fa || k == fb) bad = 1;
        k++;
      end
      if (!bad) begin
        lo = tbl_lo[v]; hi = tbl_hi[v]; opts = lo[47:32];
        if (!opts[15] || opts[11:9] != 3'b111 || opts[12]) bad = 1;
      end
      if (!bad) begin
        top = rsp & ~64'hF;
        n = has_code(v) ? 6 : 5;
        fr[0] = {48'd0, ss}; fr[1] = rsp; fr[2] = rfl; fr[3] = {48'd0, cs}; fr[4] = rip; fr[5] = e;
        for (int i = 0; i < n && !bad; i++) begin
          add_exp(top - 64'(8 * (i + 1)), 1'b1, fr[i]);
          if (k == fa || k == fb) bad = 1;
          k++;
        end
        if (!bad) begin
          fin = 1; exp_shut = 0;
          exp_rip = {hi[31:0], lo[63:48], lo[15:0]};
          exp_cs  = lo[31:16];
          exp_rsp = top - 64'(8 * n);
          exp_rfl = opts[8] ? rfl : (rfl & ~(64'd1 << 9));
        end
      end
      if (bad) begin
        if (lvl) begin fin = 1; exp_shut = 1; end
        else begin lvl = 1; v = 8; e = 64'd0; end
      end
    end
  endtask

  task automatic run_case(input int vec, input logic [63:0] rsp, input int f1, input int f2,
                          input bit stall, input bit noise, input string oreq);
    logic [63:0] err, rfl, rip;
    logic [15:0] ss, cs;
    int cyc;
    logic got_shut;
    err = {$urandom(), $urandom()}; rfl = {$urandom(), $urandom()}; rip = {$urandom(), $urandom()};
    ss = 16'($urandom()); cs = 16'($urandom());
    @(negedge clk);
    fa = f1; fb = f2; acc_k = 0; act_n = 0; stall_on = stall;
    model(vec, err, ss, rsp, rfl, cs, rip);
    exc_vec = 8'(vec); exc_err = err; cur_rsp = rsp; cur_rflags = rfl; cur_rip = rip;
    cur_ss = ss; cur_cs = cs; exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    check("R10", "busy after accept", {63'd0, busy}, 64'd1);
    if (noise) begin
      // second request with changed core state while busy: must be ignored
      exc_req = 1'b1; exc_vec = 8'(vec) ^ 8'h05; exc_err = ~err; cur_rsp = ~rsp;
      cur_rflags = ~rfl; cur_rip = ~rip; cur_ss = ~ss; cur_cs = ~cs;
      @(negedge clk);
      exc_req = 1'b0;
    end
    cyc = 0;
    while (!(done || shutdown) && cyc < 400) begin @(negedge clk); cyc++; end
    if (cyc >= 400) begin n_chk++; n_fail++; $display("FAIL %s no done or shutdown: actual none expected pulse", oreq); return; end
    got_shut = shutdown;
    check(oreq, "shutdown outcome", {63'd0, got_shut}, {63'd0, exp_shut});
    check("R10", "busy with pulse", {63'd0, busy}, 64'd1);
    if (!got_shut && !exp_shut) begin
      check("R2", "new_rip", new_rip, exp_rip);
      check("R2", "new_cs", {48'd0, new_cs}, {48'd0, exp_cs});
      check("R6", "new_rflags", new_rflags, exp_rfl);
      check("R11", "new_rsp", new_rsp, exp_rsp);
    end
    check("R9", "access count", 64'(act_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++) begin
      check(exp_wr[i] ? "R7" : "R1", "access address", act_addr[i], exp_addr[i]);
      check("R8", "access kind", {63'd0, act_wr[i]}, {63'd0, exp_wr[i]});
      check("R8", "push data", act_data[i], exp_data[i]);
    end
    @(negedge clk);
    check("R10", "busy after pulse", {62'd0, busy, done | shutdown}, 64'd0);
    stall_on = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] op;
    void'($urandom(32'h1D7E_5EED));
    rst_n = 1'b0; exc_req = 1'b0; exc_vec = '0; exc_err = '0; cur_rsp = '0; cur_ss = '0;
    cur_rflags = '0; cur_cs = '0; cur_rip = '0; stall_on = 0; fa = -1; fb = -1; acc_k = 0; act_n = 0;
    idt_base = {$urandom(), $urandom() & 32'hFFFF_F000} + 64'd8;
    for (int v = 0; v < 256; v++) begin
      op = ($urandom() % 2 == 0) ? 16'h8E00 : 16'h8F00;
      if (v >= 32 && $urandom() % 6 == 0)
        op = ($urandom() % 2 == 0) ? (op & 16'h7FFF) : (op ^ 16'h0200);
      set_gate(v, {$urandom(), $urandom()}, 16'($urandom()), op);
    end
    set_gate(3,  64'h1111_2222_3333_4444, 16'h0010, 16'h8E00);
    set_gate(14, 64'hFFFF_8000_0012_3456, 16'h0018, 16'h8F00);
    set_gate(5,  64'h5, 16'h0008, 16'h0E00);
    set_gate(6,  64'h6, 16'h0008, 16'h9E00);
    set_gate(8,  64'hFFFF_FFFF_8000_0808, 16'h0020, 16'h8E00);

    repeat (4) @(negedge clk);
    check("R10", "reset busy/done/shutdown", {61'd0, busy, done, shutdown}, 64'd0);
    check("R10", "reset memory idle", {62'd0, rd_en, wr_en}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_case(3,  64'h0000_7FFF_FFFF_E123, -1, -1, 0, 0, "R2");  // interrupt gate, no code
    run_case(14, 64'h0000_7FFF_0000_0000, -1, -1, 0, 0, "R9");  // trap gate, code, aligned rsp
    run_case(17, 64'h0000_0000_1234_567F, -1, -1, 1, 1, "R10"); // code vector, stalls, ignored request
    run_case(5,  64'h0000_0000_0008_0008, -1, -1, 0, 0, "R3");  // not present
    run_case(6,  64'h0000_0000_0008_0009, -1, -1, 0, 0, "R3");  // bit 12 set
    run_case(13, 64'h0000_0000_0009_0000, 3, -1, 0, 0, "R4");   // fault on second push
    run_case(0,  64'h0000_0000_0009_0400, 1, -1, 1, 0, "R4");   // fault on gate high read
    run_case(8,  64'h0000_0000_000A_0000, -1, -1, 0, 0, "R9");  // direct double fault
    run_case(8,  64'h0000_0000_000A_0000, 1, -1, 0, 0, "R5");   // double fault read fault
    run_case(0,  64'h0000_0000_000B_0000, 0, 4, 0, 1, "R5");    // escalate, then fault in push
    tbl_lo[8][47] = 1'b0;
    run_case(5,  64'h0000_0000_000C_0000, -1, -1, 0, 0, "R5");  // double-fault gate unusable
    tbl_lo[8][47] = 1'b1;

    for (int i = 0; i < 80; i++) begin
      int v, f1, f2;
      v  = ($urandom() % 3 == 0) ? int'($urandom() % 32) : int'($urandom() % 256);
      f1 = ($urandom() % 3 == 0) ? int'($urandom() % 14) : -1;
      f2 = ($urandom() % 4 == 0) ? int'($urandom() % 14) : -1;
      run_case(v, {$urandom(), $urandom()}, f1, f2, bit'($urandom() % 2), bit'($urandom() % 4 == 0), "R4");
    end

    finish_run();
  end

endmodule